// File: doc/BRIEF.md
# Key-Unlocked Protected Register Write Gate

This block guards a small set of system-control registers against stray writes. Two registers sit behind the guard: a device-configuration word and a clock-divider word. Writes to either register take effect only when the unlock key has just been written to a separate lock register. Each key admits exactly one protected write, and the guard closes again after that write. Both protected registers can be read at any time, so software can read a value, modify it and write it back. Each write-back needs its own key.

One bit of the configuration word requests a software reset. Software first sets this bit and then clears it, and each of those writes needs its own unlock. When the bit goes from 1 to 0 through an accepted write, the block drives a reset request that stays high for a fixed number of cycles. A write to a protected register while the guard is locked is dropped, and it sets a sticky violation flag that software can read back. The block has a simple register bus with address, write data, write strobe and combinational read data.

Top module: `cfg_write_guard`

Register map (word addresses): 0 = lock register, 1 = configuration word, 2 = divider word, 3 = violation status. The reset-request bit is bit 0 of the configuration word. The violation flag is bit 0 of the status word.

## Requirements
- R1: After reset the guard is locked, both protected registers and the violation flag are 0, and `sys_rst_req` is low.
- R2: A write of exactly 0x000000AA to address 0 unlocks the guard. A write of any other value to address 0 leaves or makes the guard locked. Reading address 0 returns 1 in bit 0 while unlocked and 0 while locked.
- R3: While the guard is unlocked, the first write to address 1 or 2 updates that register and locks the guard again. A second write without a new key is dropped.
- R4: A write to address 1 or 2 while the guard is locked leaves the register unchanged. It also sets the violation flag (address 3, bit 0), which stays at 1 until reset.
- R5: Addresses 1 and 2 read back their stored value at any time, whether the guard is locked or unlocked.
- R6: An accepted write to address 1 that changes bit 0 from 1 to 0 raises `sys_rst_req` from the next cycle, for exactly 16 cycles.
- R7: If another such 1-to-0 change is accepted while the pulse is running, the 16-cycle count restarts from that write.
- R8: An accepted write to address 1 that leaves bit 0 at 0, or that sets it to 1, starts no reset pulse.
- R9: Writes to addresses other than 0, 1 and 2 leave the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_req | output | 1 | Software reset request pulse |

## Verification
Two functions can overlap. A reset pulse can already be counting down when new unlocked writes arrive at the configuration word. If one of those writes clears the reset bit again, the count must restart rather than run out or stack. The bench provokes this by starting a pulse and then, five cycles later, issuing an unlock/set pair and an unlock/clear pair. A reference model steps through each cycle and compares the request line and the read data every clock. A directed count then confirms that exactly 16 high cycles follow the second trigger.

// File: rtl/cfg_write_guard.sv
module cfg_write_guard #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter logic [DATA_W-1:0] KEY = 'hAA,
  parameter int PULSE_LEN = 16,
  parameter int RST_BIT   = 0,
  parameter logic [ADDR_W-1:0] A_LOCK = 0,
  parameter logic [ADDR_W-1:0] A_CFG  = 1,
  parameter logic [ADDR_W-1:0] A_DIV  = 2,
  parameter logic [ADDR_W-1:0] A_STAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_req
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic              unlocked, viol_q;
  logic [DATA_W-1:0] cfg_q, div_q;
  logic [CNT_W-1:0]  cnt_q;

  wire hit_lock = bus_we && (bus_addr == A_LOCK);
  wire hit_cfg  = bus_we && (bus_addr == A_CFG);
  wire hit_div  = bus_we && (bus_addr == A_DIV);
  wire hit_prot = hit_cfg || hit_div;
  wire commit   = hit_prot && unlocked;
  wire rst_fall = commit && hit_cfg && cfg_q[RST_BIT] && !bus_wdata[RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      viol_q   <= 1'b0;
      cfg_q    <= '0;
      div_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (hit_lock)
        unlocked <= (bus_wdata == KEY);
      else if (hit_prot)
        unlocked <= 1'b0;
      if (hit_prot && !unlocked)
        viol_q <= 1'b1;
      if (commit && hit_cfg) cfg_q <= bus_wdata;
      if (commit && hit_div) div_q <= bus_wdata;
      if (rst_fall)
        cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sys_rst_req = (cnt_q != '0);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LOCK:  bus_rdata[0] = unlocked;
      A_CFG:   bus_rdata    = cfg_q;
      A_DIV:   bus_rdata    = div_q;
      A_STAT:  bus_rdata[0] = viol_q;
      default: bus_rdata    = '0;
    endcase
  end
endmodule

// File: rtl/cfg_write_guard_chk.sv
module cfg_write_guard_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter logic [DATA_W-1:0] KEY = 'hAA,
  parameter int RST_BIT = 0,
  parameter logic [ADDR_W-1:0] A_LOCK = 0,
  parameter logic [ADDR_W-1:0] A_CFG  = 1,
  parameter logic [ADDR_W-1:0] A_DIV  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              unlocked,
  input logic              viol_q,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] div_q,
  input logic              sys_rst_req
);
  wire prot_wr = bus_we && (bus_addr == A_CFG || bus_addr == A_DIV);

  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LOCK && bus_wdata != KEY) |=> !unlocked); // R2

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr |=> !unlocked); // R3

  AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && !unlocked) |=> ($stable(cfg_q) && $stable(div_q) && viol_q)); // R4

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> viol_q); // R4

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(bus_we && bus_addr == A_CFG && unlocked &&
                                 cfg_q[RST_BIT] && !bus_wdata[RST_BIT])); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_req && !(bus_we && bus_addr == A_CFG && unlocked &&
      cfg_q[RST_BIT] && !bus_wdata[RST_BIT])) |=> !sys_rst_req); // R8
endmodule

bind cfg_write_guard cfg_write_guard_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY), .RST_BIT(RST_BIT),
  .A_LOCK(A_LOCK), .A_CFG(A_CFG), .A_DIV(A_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .unlocked(unlocked), .viol_q(viol_q), .cfg_q(cfg_q),
  .div_q(div_q), .sys_rst_req(sys_rst_req)
);

// File: tb/cfg_write_guard_test.sv
`timescale 1ns/1ps
module cfg_write_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;

  int tests = 0, fails = 0;

  cfg_write_guard uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  bit          m_unl, m_viol;
  logic [31:0] m_cfg, m_div;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_unl <= 0; m_viol <= 0; m_cfg <= 0; m_div <= 0; m_cnt <= 0;
    end else begin
      bit trig;
      trig = 0;
      if (bus_we) begin
        case (bus_addr)
          4'd0: m_unl <= (bus_wdata == 32'hAA);
          4'd1, 4'd2: begin
            if (m_unl) begin
              if (bus_addr == 4'd1) begin
                trig = m_cfg[0] && !bus_wdata[0];
                m_cfg <= bus_wdata;
              end else m_div <= bus_wdata;
            end else m_viol <= 1;
            m_unl <= 0;
          end
          default: ;
        endcase
      end
      if (trig) m_cnt <= 16;
      else if (m_cnt > 0) m_cnt <= m_cnt - 1;
    end
  end

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'd0: return {31'd0, m_unl};
      4'd1: return m_cfg;
      4'd2: return m_div;
      4'd3: return {31'd0, m_viol};
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    tests++;
    if (sys_rst_req !== (m_cnt != 0)) begin
      fails++;
      $display("FAIL R6 per-cycle sys_rst_req act=%0b exp=%0b", sys_rst_req, m_cnt != 0);
    end
    tests++;
    if (bus_rdata !== exp_rd(bus_addr)) begin
      fails++;
      $display("FAIL %s per-cycle rdata addr=%0d act=%h exp=%h",
               bus_addr == 0 ? "R2" : (bus_addr == 3 ? "R4" : "R5"),
               bus_addr, bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, string tag, logic [31:0] exp);
    @(negedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic count_high(string tag, int exp);
    int n = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (sys_rst_req) n++;
    end
    check(tag, n, exp);
  endtask

  task automatic quiet(string tag);
    int n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sys_rst_req) n++;
    end
    check(tag, n, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'd0, "R1 lock after reset", 0);
    rd(4'd1, "R1 cfg after reset", 0);
    rd(4'd3, "R1 viol after reset", 0);
    check("R1 rst_req after reset", {31'd0, sys_rst_req}, 0);

    wr(4'd1, 32'h5);
    rd(4'd1, "R4 locked write ignored", 0);
    rd(4'd3, "R4 viol set", 1);

    wr(4'd0, 32'h55);
    rd(4'd0, "R2 wrong key stays locked", 0);
    wr(4'd0, 32'hAA);
    rd(4'd0, "R2 key unlocks", 1);
    wr(4'd7, 32'h1);
    rd(4'd0, "R9 other address keeps unlock", 1);
    wr(4'd0, 32'h1AA);
    rd(4'd0, "R2 wide non-key relocks", 0);

    wr(4'd0, 32'hAA);
    wr(4'd1, 32'h1);
    rd(4'd1, "R3 unlocked write lands", 1);
    rd(4'd0, "R3 lock closes after write", 0);
    wr(4'd2, 32'h1234);
    rd(4'd2, "R3 second write dropped", 0);
    wr(4'd0, 32'hAA);
    wr(4'd2, 32'h1234);
    rd(4'd2, "R5 divider read while locked", 32'h1234);
    rd(4'd3, "R4 viol sticky", 1);

    wr(4'd0, 32'hAA);
    wr(4'd1, 32'h0);
    count_high("R6 pulse length", 16);

    wr(4'd0, 32'hAA);
    wr(4'd1, 32'h0);
    quiet("R8 clear when already 0");
    wr(4'd0, 32'hAA);
    wr(4'd1, 32'h3);
    quiet("R8 setting bit gives no pulse");
    rd(4'd1, "R5 cfg read", 32'h3);

    wr(4'd0, 32'hAA);
    wr(4'd1, 32'h2);
    repeat (5) @(negedge clk);
    wr(4'd0, 32'hAA);
    wr(4'd1, 32'h1);
    wr(4'd0, 32'hAA);
    wr(4'd1, 32'h0);
    count_high("R7 restart after retrigger", 16);

    finish_run();
  end
endmodule